// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block keeps exceptions precise in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each instruction entering decode brings a small status vector along with its own PC and the PC that follows it in program order. Any stage may post a cause into the vector of the instruction it holds. The vector travels with that instruction, and once any bit is set, the instruction's memory write and register write are suppressed. Causes are acted on only when the instruction reaches writeback. A fault that appears early in time on a younger instruction therefore never pre-empts an older one.

When an instruction with a non-empty vector sits in writeback, the block takes the exception in that cycle. It raises a flush that empties every tracked stage at the next edge and drops the instruction now in fetch. It asks fetch to redirect to a fixed trap address. It records the cause code and two restart PCs: the faulting instruction's PC and its program-order successor. The second PC is the branch target when the faulting instruction sits in a delay slot, so a one-slot delayed branch can be restarted correctly.

Top module: `excTracker`

## Requirements
- R1: After reset no stage holds an instruction, `excFlush`, `memWriteKill` and `wbWriteKill` are low, and `excPc`, `excNextPc` and `excCause` are zero.
- R2: A cause posted in any stage travels with its instruction. `excFlush` rises in exactly the cycle that instruction is in writeback, which is four cycles after the cycle it was in fetch when the pipeline is not flushed.
- R3: `memWriteKill` is high in a cycle when the memory stage holds an instruction that already carries a cause, or that raises a memory-stage fault in that same cycle.
- R4: `wbWriteKill` is high exactly when the writeback instruction carries any cause.
- R5: Cause codes are: 0 fetch page fault, 1 fetch misaligned, 2 fetch protection, 3 undefined opcode, 4 arithmetic, 5 data page fault, 6 data misaligned, 7 data protection. When several causes are posted, the lowest code is reported.
- R6: An older instruction's fault is taken before a younger one's. If a load faults in memory while the next instruction faults in execute in the same cycle, the reported cause is 5 and the younger fault is discarded.
- R7: In the take cycle `memWriteKill` is high whenever the memory stage is occupied. After the edge all stages are empty, so `excFlush` is low in the next cycle and the instruction that was in fetch never reaches writeback.
- R8: At the edge ending a take cycle, `excPc`, `excNextPc` and `excCause` load the writeback instruction's PC, its successor PC and its cause. Otherwise they hold their value.
- R9: `trapPc` always equals the trap vector parameter, and the fetch redirect is signalled by `excFlush`.
- R10: Fault inputs for a stage that holds no instruction are ignored and never lead to a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ifValid | input | 1 | An instruction is in fetch this cycle |
| ifPc | input | PC_W | PC of the fetch instruction |
| ifNextPc | input | PC_W | Program-order successor PC (branch target for a delay slot) |
| ifPageFault | input | 1 | Instruction page fault in fetch |
| ifMisalign | input | 1 | Misaligned instruction address |
| ifProtect | input | 1 | Protection violation on instruction fetch |
| idUndefOp | input | 1 | Undefined opcode in decode |
| exArith | input | 1 | Arithmetic exception in execute |
| memPageFault | input | 1 | Data page fault in memory stage |
| memMisalign | input | 1 | Misaligned data access |
| memProtect | input | 1 | Protection violation on data access |
| memWriteKill | output | 1 | Suppress the memory-stage store |
| wbWriteKill | output | 1 | Suppress the writeback register write |
| excFlush | output | 1 | Exception taken: flush all stages and fetch from the trap vector |
| trapPc | output | PC_W | Trap handler address |
| excPc | output | PC_W | Captured PC of the faulting instruction |
| excNextPc | output | PC_W | Captured successor PC of the faulting instruction |
| excCause | output | 3 | Captured cause code |

## Verification
The assertions assume that the fetch and stage fault inputs are changed only between clock edges and that reset is held for at least one edge. The stimulus drives every input at the falling edge and keeps it stable through the rising edge. Fault inputs are asserted freely, including on empty stages and on several stages at once. A fault raised for a stage is taken to belong to whatever instruction occupies that stage in that cycle. The checks rely on this, and the stimulus never presumes any other ownership.

// File: rtl/excTrackerPkg.sv
package excTrackerPkg;
  localparam int NUM_SRC = 8;
  localparam int CAUSE_W = $clog2(NUM_SRC);
  localparam int NUM_STG = 4;  // decode, execute, memory, writeback

  // bit positions equal the cause code; lower means earlier in program flow
  localparam int BIT_IF_PAGE  = 0;
  localparam int BIT_IF_ALIGN = 1;
  localparam int BIT_IF_PROT  = 2;
  localparam int BIT_ID_UNDEF = 3;
  localparam int BIT_EX_ARITH = 4;
  localparam int BIT_MEM_PAGE = 5;
  localparam int BIT_MEM_ALIGN = 6;
  localparam int BIT_MEM_PROT = 7;

  typedef logic [NUM_SRC-1:0] excVec_t;
  typedef logic [CAUSE_W-1:0] cause_t;

  typedef struct packed {
    logic   flush;
    logic   capture;
    cause_t cause;
  } ctrlStrobes_t;
endpackage

// File: rtl/excTrackerDp.sv
module excTrackerDp
  import excTrackerPkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ifValid,
  input  logic [PC_W-1:0] ifPc,
  input  logic [PC_W-1:0] ifNextPc,
  input  excVec_t         ifRaise,
  input  excVec_t         idRaise,
  input  excVec_t         exRaise,
  input  excVec_t         memRaise,
  input  ctrlStrobes_t    strobes,
  output logic            memValid,
  output excVec_t         memPosted,
  output logic            wbValid,
  output excVec_t         wbVec,
  output logic [PC_W-1:0] excPc,
  output logic [PC_W-1:0] excNextPc,
  output cause_t          excCause
);
  logic            stgValid [NUM_STG];
  logic [PC_W-1:0] stgPc    [NUM_STG];
  logic [PC_W-1:0] stgNx    [NUM_STG];
  excVec_t         stgVec   [NUM_STG];

  logic            entValid [NUM_STG];
  logic [PC_W-1:0] entPc    [NUM_STG];
  logic [PC_W-1:0] entNx    [NUM_STG];
  excVec_t         entVec   [NUM_STG];
  excVec_t         stgRaise [NUM_STG-1];

  assign stgRaise[0] = idRaise;
  assign stgRaise[1] = exRaise;
  assign stgRaise[2] = memRaise;

  assign entValid[0] = ifValid;
  assign entPc[0]    = ifPc;
  assign entNx[0]    = ifNextPc;
  assign entVec[0]   = ifValid ? ifRaise : '0;

  genvar s;
  generate
    for (s = 1; s < NUM_STG; s++) begin : gEntry
      assign entValid[s] = stgValid[s-1];
      assign entPc[s]    = stgPc[s-1];
      assign entNx[s]    = stgNx[s-1];
      assign entVec[s]   = stgValid[s-1] ? (stgVec[s-1] | stgRaise[s-1]) : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_STG; k++) begin
      if (!rstN || strobes.flush) begin
        stgValid[k] <= 1'b0;
        stgPc[k]    <= '0;
        stgNx[k]    <= '0;
        stgVec[k]   <= '0;
      end else begin
        stgValid[k] <= entValid[k];
        stgPc[k]    <= entPc[k];
        stgNx[k]    <= entNx[k];
        stgVec[k]   <= entVec[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excPc     <= '0;
      excNextPc <= '0;
      excCause  <= '0;
    end else if (strobes.capture) begin
      excPc     <= stgPc[NUM_STG-1];
      excNextPc <= stgNx[NUM_STG-1];
      excCause  <= strobes.cause;
    end
  end

  assign memValid  = stgValid[NUM_STG-2];
  assign memPosted = entVec[NUM_STG-1];
  assign wbValid   = stgValid[NUM_STG-1];
  assign wbVec     = stgVec[NUM_STG-1];
endmodule

// File: rtl/excTrackerCtrl.sv
module excTrackerCtrl
  import excTrackerPkg::*;
(
  input  logic         memValid,
  input  excVec_t      memPosted,
  input  logic         wbValid,
  input  excVec_t      wbVec,
  output ctrlStrobes_t strobes,
  output logic         memWriteKill,
  output logic         wbWriteKill
);
  logic   takeNow;
  cause_t firstCause;

  assign takeNow = wbValid && (wbVec != '0);

  // scan from the latest source down so the earliest posted one is kept
  always_comb begin
    firstCause = '0;
    for (int b = NUM_SRC - 1; b >= 0; b--) begin
      if (wbVec[b]) firstCause = cause_t'(b);
    end
  end

  assign strobes.flush   = takeNow;
  assign strobes.capture = takeNow;
  assign strobes.cause   = firstCause;

  assign wbWriteKill  = takeNow;
  assign memWriteKill = memValid && ((memPosted != '0) || takeNow);
endmodule

// File: rtl/excTracker.sv
module excTracker
  import excTrackerPkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ifValid,
  input  logic [PC_W-1:0]    ifPc,
  input  logic [PC_W-1:0]    ifNextPc,
  input  logic               ifPageFault,
  input  logic               ifMisalign,
  input  logic               ifProtect,
  input  logic               idUndefOp,
  input  logic               exArith,
  input  logic               memPageFault,
  input  logic               memMisalign,
  input  logic               memProtect,
  output logic               memWriteKill,
  output logic               wbWriteKill,
  output logic               excFlush,
  output logic [PC_W-1:0]    trapPc,
  output logic [PC_W-1:0]    excPc,
  output logic [PC_W-1:0]    excNextPc,
  output logic [CAUSE_W-1:0] excCause
);
  excVec_t      ifRaise, idRaise, exRaise, memRaise;
  ctrlStrobes_t strobes;
  logic         memOcc, wbOcc;
  excVec_t      memPosted, wbVec;

  always_comb begin
    ifRaise  = '0;
    idRaise  = '0;
    exRaise  = '0;
    memRaise = '0;
    ifRaise[BIT_IF_PAGE]    = ifPageFault;
    ifRaise[BIT_IF_ALIGN]   = ifMisalign;
    ifRaise[BIT_IF_PROT]    = ifProtect;
    idRaise[BIT_ID_UNDEF]   = idUndefOp;
    exRaise[BIT_EX_ARITH]   = exArith;
    memRaise[BIT_MEM_PAGE]  = memPageFault;
    memRaise[BIT_MEM_ALIGN] = memMisalign;
    memRaise[BIT_MEM_PROT]  = memProtect;
  end

  excTrackerDp #(.PC_W(PC_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .ifValid(ifValid), .ifPc(ifPc), .ifNextPc(ifNextPc),
    .ifRaise(ifRaise), .idRaise(idRaise), .exRaise(exRaise), .memRaise(memRaise),
    .strobes(strobes),
    .memValid(memOcc), .memPosted(memPosted),
    .wbValid(wbOcc), .wbVec(wbVec),
    .excPc(excPc), .excNextPc(excNextPc), .excCause(excCause)
  );

  excTrackerCtrl ctrl_i (
    .memValid(memOcc), .memPosted(memPosted),
    .wbValid(wbOcc), .wbVec(wbVec),
    .strobes(strobes),
    .memWriteKill(memWriteKill), .wbWriteKill(wbWriteKill)
  );

  assign excFlush = strobes.flush;
  assign trapPc   = TRAP_VEC;
endmodule

// File: rtl/excTrackerChk.sv
module excTrackerChk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            excFlush,
  input logic            memWriteKill,
  input logic            wbWriteKill,
  input logic            memOcc,
  input logic [PC_W-1:0] excPc,
  input logic [2:0]      excCause
);
  assert_flush_kills_wb_R4: assert property (@(posedge clk) disable iff (!rstN)
    excFlush |-> wbWriteKill);

  assert_flush_kills_mem_R7: assert property (@(posedge clk) disable iff (!rstN)
    (excFlush && memOcc) |-> memWriteKill);

  assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (!rstN)
    excFlush |=> !excFlush);

  assert_capture_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    !excFlush |=> ($stable(excPc) && $stable(excCause)));
endmodule

bind excTracker excTrackerChk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rstN(rstN), .excFlush(excFlush),
  .memWriteKill(memWriteKill), .wbWriteKill(wbWriteKill),
  .memOcc(memOcc), .excPc(excPc), .excCause(excCause)
);

// File: tb/excTracker_tb.sv
`timescale 1ns/1ps
module excTracker_tb_top;
  localparam int PC_W = 32;
  localparam logic [31:0] TRAP = 32'h0000_0080;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ifValid = 0, ifPageFault = 0, ifMisalign = 0, ifProtect = 0;
  logic idUndefOp = 0, exArith = 0;
  logic memPageFault = 0, memMisalign = 0, memProtect = 0;
  logic [31:0] ifPc = 0, ifNextPc = 0;
  logic memWriteKill, wbWriteKill, excFlush;
  logic [31:0] trapPc, excPc, excNextPc;
  logic [2:0] excCause;

  always #4 clk = ~clk;

  excTracker #(.PC_W(PC_W), .TRAP_VEC(TRAP)) dut_i (
    .clk(clk), .rstN(rstN), .ifValid(ifValid), .ifPc(ifPc), .ifNextPc(ifNextPc),
    .ifPageFault(ifPageFault), .ifMisalign(ifMisalign), .ifProtect(ifProtect),
    .idUndefOp(idUndefOp), .exArith(exArith),
    .memPageFault(memPageFault), .memMisalign(memMisalign), .memProtect(memProtect),
    .memWriteKill(memWriteKill), .wbWriteKill(wbWriteKill), .excFlush(excFlush),
    .trapPc(trapPc), .excPc(excPc), .excNextPc(excNextPc), .excCause(excCause)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state: index 0 decode, 1 execute, 2 memory, 3 writeback
  bit        mV[4];
  bit [31:0] mPc[4], mNx[4];
  bit [7:0]  mVec[4];
  bit [31:0] mEpc, mEnx;
  bit [2:0]  mCause;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] memRaiseNow();
    return {memProtect, memMisalign, memPageFault, 5'b0};
  endfunction

  function automatic bit [2:0] lowestCode(bit [7:0] v);
    for (int b = 0; b < 8; b++) if (v[b]) return 3'(b);
    return 3'd0;
  endfunction

  // compare on this cycle, then advance the model across the edge
  task automatic cycle();
    bit take;
    bit [7:0] postMem;
    #1;
    take    = mV[3] && (mVec[3] != 0);
    postMem = mV[2] ? (mVec[2] | memRaiseNow()) : 8'h0;
    chk("R2", "excFlush", excFlush, take);
    chk("R4", "wbWriteKill", wbWriteKill, take);
    chk("R3", "memWriteKill", memWriteKill, mV[2] && (postMem != 0 || take));
    chk("R9", "trapPc", trapPc, TRAP);
    chk("R8", "excPc", excPc, mEpc);
    chk("R8", "excNextPc", excNextPc, mEnx);
    chk("R5", "excCause", excCause, mCause);
    @(posedge clk);
    if (take) begin
      mEpc = mPc[3]; mEnx = mNx[3]; mCause = lowestCode(mVec[3]);
      for (int k = 0; k < 4; k++) begin mV[k] = 0; mVec[k] = 0; mPc[k] = 0; mNx[k] = 0; end
    end else begin
      mV[3] = mV[2]; mPc[3] = mPc[2]; mNx[3] = mNx[2]; mVec[3] = postMem;
      mV[2] = mV[1]; mPc[2] = mPc[1]; mNx[2] = mNx[1];
      mVec[2] = mV[1] ? (mVec[1] | {3'b0, exArith, 4'b0}) : 8'h0;
      mV[1] = mV[0]; mPc[1] = mPc[0]; mNx[1] = mNx[0];
      mVec[1] = mV[0] ? (mVec[0] | {4'b0, idUndefOp, 3'b0}) : 8'h0;
      mV[0] = ifValid; mPc[0] = ifPc; mNx[0] = ifNextPc;
      mVec[0] = ifValid ? {5'b0, ifProtect, ifMisalign, ifPageFault} : 8'h0;
    end
    @(negedge clk);
  endtask

  task automatic clearIn();
    ifValid = 0; ifPageFault = 0; ifMisalign = 0; ifProtect = 0;
    idUndefOp = 0; exArith = 0; memPageFault = 0; memMisalign = 0; memProtect = 0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mV[k] = 0; mVec[k] = 0; mPc[k] = 0; mNx[k] = 0; end
    mEpc = 0; mEnx = 0; mCause = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "excFlush after reset", excFlush, 0);
    chk("R1", "memWriteKill after reset", memWriteKill, 0);
    chk("R1", "wbWriteKill after reset", wbWriteKill, 0);
    chk("R1", "excPc after reset", excPc, 0);
    chk("R1", "excCause after reset", excCause, 0);
    @(negedge clk);
    rstN = 1;

    // R10: faults on an empty pipeline
    memPageFault = 1; exArith = 1; idUndefOp = 1;
    for (int i = 0; i < 6; i++) begin
      cycle();
      chk("R10", "no flush on empty stages", excFlush, 0);
    end
    clearIn();

    // R2: fetch fault taken four cycles after fetch; delay-slot successor PC kept
    ifValid = 1; ifPc = 32'h200; ifNextPc = 32'h340; ifMisalign = 1;
    cycle(); clearIn();
    cycle(); cycle(); cycle();
    #1 chk("R2", "flush four cycles after fetch", excFlush, 1);
    cycle();
    chk("R8", "excNextPc after take", excNextPc, 32'h340);
    chk("R5", "cause fetch misaligned", excCause, 1);

    // R6/R7: load faults in memory while successor faults in execute
    ifValid = 1; ifPc = 32'h100; ifNextPc = 32'h104;
    cycle();
    ifPc = 32'h104; ifNextPc = 32'h108;
    cycle();
    ifPc = 32'h108; ifNextPc = 32'h10c;
    cycle();
    ifPc = 32'h10c; ifNextPc = 32'h110; memPageFault = 1; exArith = 1;
    cycle(); clearIn(); ifValid = 1; ifPc = 32'h110; ifNextPc = 32'h114;
    #1;
    chk("R6", "older fault taken", excFlush, 1);
    chk("R7", "younger mem write suppressed", memWriteKill, 1);
    cycle(); clearIn();
    chk("R6", "cause data page fault", excCause, 5);
    chk("R8", "excPc of load", excPc, 32'h100);
    for (int i = 0; i < 5; i++) begin
      cycle();
      chk("R7", "flushed instructions never taken", excFlush, 0);
    end

    // R5: several causes on one instruction
    ifValid = 1; ifPc = 32'h400; ifNextPc = 32'h404; ifProtect = 1;
    cycle(); clearIn();
    idUndefOp = 1; cycle(); clearIn();
    exArith = 1; cycle(); clearIn();
    memMisalign = 1; cycle(); clearIn();
    cycle();
    chk("R5", "lowest code wins", excCause, 2);

    // randomized traffic compared every cycle
    begin
      bit [31:0] pc = 32'h1000;
      for (int i = 0; i < 4000; i++) begin
        ifValid = ($urandom_range(0, 9) < 8);
        ifPc = pc;
        ifNextPc = ($urandom_range(0, 7) == 0) ? (32'h2000 + ($urandom_range(0, 255) << 2)) : pc + 4;
        pc = ifNextPc;
        ifPageFault  = ($urandom_range(0, 99) < 2);
        ifMisalign   = ($urandom_range(0, 99) < 2);
        ifProtect    = ($urandom_range(0, 99) < 2);
        idUndefOp    = ($urandom_range(0, 99) < 3);
        exArith      = ($urandom_range(0, 99) < 3);
        memPageFault = ($urandom_range(0, 99) < 3);
        memMisalign  = ($urandom_range(0, 99) < 2);
        memProtect   = ($urandom_range(0, 99) < 2);
        cycle();
      end
    end
    clearIn();
    repeat (6) cycle();
    done = 1;
    finishRun();
  end
endmodule